// File: doc/BRIEF.md
# Serial Life Cellular Automaton Engine

This block holds a Conway Life field of ROWS x COLS cells in one circular shift register. It computes each new generation one cell per clock. While a generation runs, the register rotates one place per clock, so the cell under evaluation always sits in the lowest bit. A position counter records which row and column that bit holds. The eight neighbours are read from fixed taps of the register. Any neighbour that would lie outside the field counts as dead, so the field does not wrap.

A new cell value cannot go straight back into the field, because later cells still need the old value. Each result therefore waits in a short delay line. It is written back at the first place where no later evaluation of the same generation can read it. After the last cell, one commit cycle stores the results still waiting in the delay line. This cycle also leaves the register aligned again, so bit `row*COLS+col` holds cell (row, col).

While idle, a surrounding controller can edit the field with a cursor (four move inputs and a flip input). It can scan the field for display through a combinational read port. A pulse on `step_req` starts exactly one generation.

Top module: `life_serial_engine`

## Requirements
- R1: After a synchronous active-low reset, every cell is dead, the cursor is at row 0, column 0, `busy` is 0 and `done` is 0.
- R2: A `step_req` sampled while idle raises `busy` for exactly ROWS*COLS+1 cycles. In the first cycle after `busy` falls, `done` is 1 for one cycle, and the new generation is visible.
- R3: A `step_req` sampled while `busy` is 1 has no effect: exactly one generation is computed per accepted request.
- R4: Each new cell value follows this rule, where S is the count of live cells in the 3x3 window including the cell itself. The cell becomes 1 when S is 3, or when S is 4 and the cell was 1. Otherwise it becomes 0.
- R5: Positions outside the field count as dead cells. Cells on opposite edges of the field do not influence each other.
- R6: While idle, each sampled move input shifts the cursor by one cell. `mv_up` decrements the row, `mv_down` increments it, `mv_left` decrements the column and `mv_right` increments it. A pair of opposite inputs sampled together cancels. A move that would leave the field leaves that coordinate unchanged.
- R7: While idle, a sampled `flip` inverts the cell under the cursor position held before any move in the same cycle. A `flip` in the cycle in which `step_req` is accepted is ignored.
- R8: Move and flip inputs sampled while `busy` is 1 are ignored.
- R9: While idle, `rd_cell` shows, without delay, the state of the cell at (`rd_row`, `rd_col`).
- R10: While idle, with no `flip` and no `step_req`, the field does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_req | input | 1 | Start one generation (accepted while idle) |
| mv_up | input | 1 | Move cursor one row toward row 0 |
| mv_down | input | 1 | Move cursor one row toward row ROWS-1 |
| mv_left | input | 1 | Move cursor one column toward column 0 |
| mv_right | input | 1 | Move cursor one column toward column COLS-1 |
| flip | input | 1 | Invert the cell under the cursor |
| busy | output | 1 | Generation in progress |
| done | output | 1 | One-cycle pulse after a generation completes |
| cur_row | output | $clog2(ROWS) | Cursor row |
| cur_col | output | $clog2(COLS) | Cursor column |
| rd_row | input | $clog2(ROWS) | Read port row |
| rd_col | input | $clog2(COLS) | Read port column |
| rd_cell | output | 1 | State of the addressed cell |

## Verification
The assertions check the control behaviour on every cycle. They confirm that `done` follows the fall of `busy`, that `busy` holds until the commit cycle, and that the cursor freezes while busy and saturates at its edges. They also confirm that the field holds still while idle and that a flip changes exactly one cell. The correctness of the computed generation cannot be expressed as a simple property, because it depends on the Life rule, the missing wrap-around and the ordering of the delayed write-back. Only the bench scenarios can show these. They compare whole fields against a reference model after blinkers, still lifes in corners, cells on opposite edges, a fully populated field and a glider.

// File: rtl/life_pkg.sv
// Shared types for the serial Life engine.
package life_pkg;

    // Engine phase: idle/editing, evaluating cells, committing the delay line.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_EVAL   = 2'd1,
        PH_COMMIT = 2'd2
    } phase_t;

endpackage

// File: rtl/life_window.sv
// Neighbourhood gather and population count.
// Takes the field register whose bit 0 is the current cell, and the logical
// row/column of that cell. Reads the eight neighbour taps, masks those that
// fall outside the field and sums the 3x3 window including the centre.
// Assumes ROWS >= 2 and COLS >= 2, both powers of two.
module life_window #(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic [ROWS*COLS-1:0]      field,
    input  logic [$clog2(ROWS)-1:0]   row,
    input  logic [$clog2(COLS)-1:0]   col,
    output logic                      centre,
    output logic [3:0]                count
);
    localparam int N    = ROWS * COLS;
    localparam int RW   = $clog2(ROWS);
    localparam int CW   = $clog2(COLS);
    // Tap positions relative to the current cell at bit 0.
    localparam int T_E  = 1;
    localparam int T_W  = N - 1;
    localparam int T_S  = COLS;
    localparam int T_SW = COLS - 1;
    localparam int T_SE = COLS + 1;
    localparam int T_N  = N - COLS;
    localparam int T_NW = N - COLS - 1;
    localparam int T_NE = N - COLS + 1;

    logic has_w, has_e, has_n, has_s;
    logic [7:0] nb;

    // Edge qualifiers: a neighbour exists only inside the field.
    always_comb begin
        has_w = (col != '0);
        has_e = (col != CW'(COLS - 1));
        has_n = (row != '0);
        has_s = (row != RW'(ROWS - 1));
    end

    // Masked neighbour bits.
    always_comb begin
        nb[0] = field[T_W]  & has_w;
        nb[1] = field[T_E]  & has_e;
        nb[2] = field[T_N]  & has_n;
        nb[3] = field[T_S]  & has_s;
        nb[4] = field[T_NW] & has_n & has_w;
        nb[5] = field[T_NE] & has_n & has_e;
        nb[6] = field[T_SW] & has_s & has_w;
        nb[7] = field[T_SE] & has_s & has_e;
    end

    assign centre = field[0];

    // Population count of the whole 3x3 window.
    always_comb begin
        count = {3'b000, field[0]};
        for (int i = 0; i < 8; i++) begin
            count = count + {3'b000, nb[i]};
        end
    end
endmodule

// File: rtl/life_rule.sv
// Next-state rule on the 3x3 window population (centre included).
// A cell lives when the window holds 3, or holds 4 and the cell is alive.
module life_rule (
    input  logic [3:0] count,
    input  logic       alive,
    output logic       next_alive
);
    // Birth/survival decision.
    always_comb begin
        next_alive = (count == 4'd3) || ((count == 4'd4) && alive);
    end
endmodule

// File: rtl/life_delay.sv
// Write-back delay line for new cell values.
// taps[0] holds the newest value; taps[k] the value pushed k pushes earlier.
// Shifts only when shift_en is high.
module life_delay #(
    parameter int DEPTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [DEPTH-1:0] taps
);
    // Push one result per evaluated cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps <= '0;
        end else if (shift_en) begin
            taps <= {taps[DEPTH-2:0], din};
        end
    end
endmodule

// File: rtl/life_cursor.sv
// Editing cursor with per-axis saturation.
// Opposite moves sampled together cancel. Moves are taken only when en=1.
module life_cursor #(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    up,
    input  logic                    down,
    input  logic                    left,
    input  logic                    right,
    output logic [$clog2(ROWS)-1:0] row,
    output logic [$clog2(COLS)-1:0] col
);
    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);

    // Row coordinate: step toward row 0 or ROWS-1, clamped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (en) begin
            if (up && !down && row != '0)
                row <= row - RW'(1);
            else if (down && !up && row != RW'(ROWS - 1))
                row <= row + RW'(1);
        end
    end

    // Column coordinate: step toward column 0 or COLS-1, clamped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
        end else if (en) begin
            if (left && !right && col != '0)
                col <= col - CW'(1);
            else if (right && !left && col != CW'(COLS - 1))
                col <= col + CW'(1);
        end
    end

    a_r8_cursor_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(row) && $stable(col)));

    a_r6_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && up && !down && row != '0) |=> (row == $past(row) - RW'(1)));

    a_r6_right_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && right && !left && col != CW'(COLS - 1)) |=> (col == $past(col) + CW'(1)));

    a_r6_top_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (row == '0 && !(en && down && !up)) |=> (row == '0));
endmodule

// File: rtl/life_serial_engine.sv
// Bit-serial Life generation engine (top).
// The field lives in one circular register. During a generation it rotates
// toward bit 0 once per clock, and bit 0 is the cell being evaluated. pos
// counts the logical index (row*COLS+col) of that cell. A new value waits in
// a COLS+1 deep delay line. It is written back at the slot where its old
// value has had its last reader. One commit cycle then stores the final COLS+1
// results. Since exactly N rotations have occurred, the register is aligned
// again when idle. Assumes ROWS, COLS >= 2, powers of two.
module life_serial_engine
    import life_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_req,
    input  logic                    mv_up,
    input  logic                    mv_down,
    input  logic                    mv_left,
    input  logic                    mv_right,
    input  logic                    flip,
    output logic                    busy,
    output logic                    done,
    output logic [$clog2(ROWS)-1:0] cur_row,
    output logic [$clog2(COLS)-1:0] cur_col,
    input  logic [$clog2(ROWS)-1:0] rd_row,
    input  logic [$clog2(COLS)-1:0] rd_col,
    output logic                    rd_cell
);
    localparam int N      = ROWS * COLS;
    localparam int RW     = $clog2(ROWS);
    localparam int CW     = $clog2(COLS);
    localparam int AW     = RW + CW;
    localparam int DEPTH  = COLS + 1;
    // Slot (after rotation) whose cell has just been read for the last time.
    localparam int WB_POS = N - COLS - 2;

    phase_t          phase;
    logic [N-1:0]    field, field_d;
    logic [AW-1:0]   pos;
    logic [AW-1:0]   cur_idx;
    logic [DEPTH-1:0] dly;
    logic            centre, new_val;
    logic [3:0]      count;

    assign busy    = (phase != PH_IDLE);
    assign cur_idx = {cur_row, cur_col};
    assign rd_cell = field[{rd_row, rd_col}];

    life_window #(.ROWS(ROWS), .COLS(COLS)) u_window (
        .field  (field),
        .row    (pos[AW-1:CW]),
        .col    (pos[CW-1:0]),
        .centre (centre),
        .count  (count)
    );

    life_rule u_rule (
        .count      (count),
        .alive      (centre),
        .next_alive (new_val)
    );

    life_delay #(.DEPTH(DEPTH)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (phase == PH_EVAL),
        .din      (new_val),
        .taps     (dly)
    );

    life_cursor #(.ROWS(ROWS), .COLS(COLS)) u_cursor (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (!busy),
        .up    (mv_up),
        .down  (mv_down),
        .left  (mv_left),
        .right (mv_right),
        .row   (cur_row),
        .col   (cur_col)
    );

    // Phase sequencing: idle -> N evaluation steps -> one commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE:   if (step_req) phase <= PH_EVAL;
                PH_EVAL:   if (pos == AW'(N - 1)) phase <= PH_COMMIT;
                PH_COMMIT: phase <= PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    // Logical index of the cell at bit 0; wraps back to 0 after N steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (phase == PH_EVAL) begin
            pos <= pos + AW'(1);
        end
    end

    // Completion pulse, raised in the first idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (phase == PH_COMMIT);
        end
    end

    // Next field: edit, rotate with delayed write-back, or final commit.
    always_comb begin
        field_d = field;
        unique case (phase)
            PH_IDLE: begin
                if (flip && !step_req) field_d[cur_idx] = ~field[cur_idx];
            end
            PH_EVAL: begin
                field_d = {field[0], field[N-1:1]};
                if (pos >= AW'(DEPTH)) field_d[WB_POS] = dly[DEPTH-1];
            end
            PH_COMMIT: begin
                for (int k = 0; k < DEPTH; k++) field_d[N-1-k] = dly[k];
            end
            default: ;
        endcase
    end

    // Field register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field <= '0;
        end else begin
            field <= field_d;
        end
    end

    a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EVAL) |=> busy);

    a_r2_aligned_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_COMMIT) |-> (pos == '0));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !flip) |=> $stable(field));

    a_r7_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && flip && !step_req) |=> ($countones(field ^ $past(field)) == 1));
endmodule

// File: tb/life_serial_engine_tb.sv
`timescale 1ns/1ps
module life_serial_engine_tb;
    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int N    = ROWS * COLS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_req = 1'b0, mv_up = 1'b0, mv_down = 1'b0;
    logic mv_left = 1'b0, mv_right = 1'b0, flip = 1'b0;
    logic busy, done, rd_cell;
    logic [2:0] cur_row, cur_col;
    logic [2:0] rd_row = '0, rd_col = '0;

    int errors = 0;
    int checks = 0;
    bit chk_on = 1'b0;
    bit finished = 1'b0;

    // Reference model state.
    int m_cnt = 0;
    bit m_done = 1'b0;
    int m_row = 0, m_col = 0;
    bit m_grid [ROWS][COLS];
    bit m_next [ROWS][COLS];

    always #4 clk = ~clk;

    life_serial_engine #(.ROWS(ROWS), .COLS(COLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_req(step_req),
        .mv_up(mv_up), .mv_down(mv_down), .mv_left(mv_left), .mv_right(mv_right),
        .flip(flip), .busy(busy), .done(done),
        .cur_row(cur_row), .cur_col(cur_col),
        .rd_row(rd_row), .rd_col(rd_col), .rd_cell(rd_cell)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Life rule with dead cells outside the field.
    task automatic model_life();
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                int s = 0;
                for (int dr = -1; dr <= 1; dr++)
                    for (int dc = -1; dc <= 1; dc++)
                        if (r+dr >= 0 && r+dr < ROWS && c+dc >= 0 && c+dc < COLS)
                            s += m_grid[r+dr][c+dc];
                m_next[r][c] = (s == 3) || (s == 4 && m_grid[r][c]);
            end
        end
    endtask

    // Cycle-accurate reference model.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_done = 0; m_row = 0; m_col = 0;
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) m_grid[r][c] = 0;
        end else if (m_cnt != 0) begin
            m_done = 0;
            m_cnt--;
            if (m_cnt == 0) begin
                m_grid = m_next;
                m_done = 1;
            end
        end else begin
            m_done = 0;
            if (step_req) begin
                model_life();
                m_cnt = N + 1;
            end else if (flip) begin
                m_grid[m_row][m_col] = !m_grid[m_row][m_col];
            end
            if (mv_up && !mv_down && m_row > 0) m_row--;
            else if (mv_down && !mv_up && m_row < ROWS-1) m_row++;
            if (mv_left && !mv_right && m_col > 0) m_col--;
            else if (mv_right && !mv_left && m_col < COLS-1) m_col++;
        end
    end

    // Per-cycle comparison of control outputs, away from the active edge.
    always @(negedge clk) begin
        if (chk_on && !finished) begin
            check(busy == (m_cnt != 0), "R2 R3 busy", busy, m_cnt != 0);
            check(done == m_done, "R2 done", done, m_done);
            check(cur_row == m_row && cur_col == m_col, "R6 R8 cursor",
                  cur_row * 8 + cur_col, m_row * 8 + m_col);
        end
    end

    // Drive a set of inputs for exactly one sampled edge.
    task automatic pulse(bit u, bit d, bit l, bit r, bit f, bit s);
        @(negedge clk);
        mv_up = u; mv_down = d; mv_left = l; mv_right = r; flip = f; step_req = s;
        @(negedge clk);
        mv_up = 0; mv_down = 0; mv_left = 0; mv_right = 0; flip = 0; step_req = 0;
    endtask

    task automatic goto_cell(int r, int c);
        while (m_row != r || m_col != c)
            pulse(m_row > r, m_row < r, m_col > c, m_col < c, 0, 0);
    endtask

    task automatic toggle(int r, int c);
        goto_cell(r, c);
        pulse(0, 0, 0, 0, 1, 0);
    endtask

    // Compare the full field through the read port (R9).
    task automatic check_grid(string tag);
        int bad = 0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                rd_row = 3'(r); rd_col = 3'(c);
                #1;
                if (rd_cell !== m_grid[r][c]) bad++;
            end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_cnt != 0) @(negedge clk);
    endtask

    task automatic run_gen(string tag);
        pulse(0, 0, 0, 0, 0, 1);
        wait_idle();
        check_grid(tag);
    endtask

    task automatic clear_field();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                if (m_grid[r][c]) toggle(r, c);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1'b1;
        check(busy == 0 && done == 0 && cur_row == 0 && cur_col == 0, "R1 reset outputs", busy, 0);
        check_grid("R1 R9 reset field");

        // R6 clamp at origin and cancelling pairs.
        pulse(1, 0, 1, 0, 0, 0);
        check(cur_row == 0 && cur_col == 0, "R6 clamp origin", cur_row, 0);
        goto_cell(3, 3);
        pulse(1, 1, 1, 1, 0, 0);
        check(cur_row == 3 && cur_col == 3, "R6 cancel", cur_col, 3);
        goto_cell(7, 7);
        pulse(0, 1, 0, 1, 0, 0);
        check(cur_row == 7 && cur_col == 7, "R6 clamp far corner", cur_row, 7);

        // R4 blinker oscillation.
        toggle(3, 2); toggle(3, 3); toggle(3, 4);
        check_grid("R7 R9 blinker drawn");
        repeat (5) @(negedge clk);
        check_grid("R10 idle hold");
        run_gen("R4 blinker gen1");
        run_gen("R4 blinker gen2");
        clear_field();

        // R5 corner block and edge blinker.
        toggle(0, 0); toggle(0, 1); toggle(1, 0); toggle(1, 1);
        toggle(3, 0); toggle(4, 0); toggle(5, 0);
        run_gen("R5 corner block edge blinker");
        run_gen("R5 edge blinker back");
        clear_field();

        // R5 no wrap between opposite edges.
        toggle(2, 7); toggle(3, 7); toggle(4, 7); toggle(3, 0); toggle(0, 4); toggle(7, 4);
        run_gen("R5 no wrap");
        clear_field();

        // R3 R8: requests and edits during a generation are ignored.
        toggle(4, 3); toggle(4, 4); toggle(4, 5);
        goto_cell(1, 1);
        pulse(0, 0, 0, 0, 0, 1);
        repeat (10) @(negedge clk);
        pulse(0, 1, 0, 1, 1, 1);
        pulse(0, 0, 0, 0, 1, 1);
        wait_idle();
        check_grid("R3 R8 single generation");
        check(cur_row == 1 && cur_col == 1, "R8 cursor kept", cur_row, 1);

        // R7 flip in the accepting cycle is ignored.
        pulse(0, 0, 0, 0, 1, 1);
        wait_idle();
        check_grid("R7 flip with step ignored");
        clear_field();

        // R4 R5 full field: only corners survive, then all die.
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) toggle(r, c);
        check_grid("R7 full field");
        run_gen("R4 R5 full field gen1");
        run_gen("R4 R5 full field gen2");
        clear_field();

        // R4 glider travelling into the corner.
        toggle(0, 1); toggle(1, 2); toggle(2, 0); toggle(2, 1); toggle(2, 2);
        for (int g = 0; g < 24; g++) run_gen("R4 R5 glider");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule